// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Port

This block takes seven asynchronous external interrupt pins, numbered 7 down to 1, into the clock domain. It shows their synchronised levels in a read-only pin-level register. For every pin a two-bit trigger mode selects level sensitivity or detection of rising, falling or both edges. A pin in an edge mode records each detected edge in a sticky flag register. Software clears a flag by writing 1 to its bit.

Software reaches the block through a small byte-addressed register port with a write strobe. Reads are combinational. Each pin drives an interrupt request that a per-pin enable register gates. In edge mode the request follows the pin's flag. In level mode it follows a low pin level. Bit 0 of every pin-indexed register is reserved and reads as 0.

Register addresses: 0 pin level (read-only), 1 edge flags (write-1-to-clear), 2 trigger modes for pins 1 to 3, 3 trigger modes for pins 4 to 7, 4 request enables. Addresses 5 to 7 read 0.

Top module: `irq_edge_port`

## Requirements
- R1: Address 0 reads the synchronised level of pin n in bit n (n = 1..7). A pin change first shows after the second rising clock edge that samples it.
- R2: Writes to address 0 change nothing. Reset does not alter what address 0 reads.
- R3: The 16-bit mode register holds pin n's mode in bits 2n+1:2n. Address 2 holds bits 7:0 and address 3 holds bits 15:8. Encoding: 00 level, 01 rising, 10 falling, 11 both. Bits 1:0 always read 0.
- R4: A pin in edge mode sets its flag (address 1, bit n) for the selected edge. The flag reads 1 after the third rising clock edge counted from the edge that first samples the pin change.
- R5: A pin in level mode (00) never sets its flag, whatever its transitions.
- R6: Flags are sticky. Writing 0 to a flag bit leaves it unchanged.
- R7: Writing 1 to a flag bit clears it.
- R8: When a new edge and a clearing write reach the same flag in the same cycle, the flag stays set.
- R9: Reset clears flags, modes and enables.
- R10: irq_o[n] = enable[n] AND (mode level ? pin n synchronised low : flag n). Enables are at address 4, bit n.
- R11: Bit 0 reads 0 at addresses 0, 1 and 4. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 7 | Asynchronous interrupt pins 7..1 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 7 | Per-pin interrupt requests 7..1 |

## Verification
The bench places a clearing write in the exact cycle that a fresh edge reaches a flag. A design that let the clear win would lose that interrupt and read 0. It toggles level-mode pins to catch a design that records edges whatever the mode, and it writes zeros and the reserved bit to catch a clear that is not bit-masked. It asserts reset in mid-run with pins held at mixed levels, so a design that reset the level path or kept stale flags, modes or enables would differ from the model. Every cycle the read data and requests are compared against a behavioural model of the latency, which exposes any extra or missing pipeline stage.

// File: rtl/irq_ep_pkg.sv
package irq_ep_pkg;
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_mode_e;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] REG_LEVEL   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_FLAGS   = 3'd1;
    localparam logic [ADDR_W-1:0] REG_MODE_LO = 3'd2;
    localparam logic [ADDR_W-1:0] REG_MODE_HI = 3'd3;
    localparam logic [ADDR_W-1:0] REG_ENABLE  = 3'd4;
endpackage

// File: rtl/irq_ep_sync.sv
module irq_ep_sync #(
    parameter int N      = 7,
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic [N:1] pin_i,
    output logic [N:1] lvl_o,
    output logic [N:1] prev_o
);
    for (genvar i = 1; i <= N; i++) begin : g_pin
        logic [STAGES:0] sh_q;
        // deliberately not reset: the level path follows the pins at all times
        always_ff @(posedge clk) begin
            sh_q <= {sh_q[STAGES-1:0], pin_i[i]};
        end
        assign lvl_o[i]  = sh_q[STAGES-1];
        assign prev_o[i] = sh_q[STAGES];
    end
endmodule

// File: rtl/irq_ep_edge.sv
module irq_ep_edge
    import irq_ep_pkg::*;
#(
    parameter int N = 7,
    localparam int MODE_W = 2 * N + 2
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [N:1]        lvl_i,
    input  logic [N:1]        prev_i,
    output logic [N:1]        hit_o,
    output logic [N:1]        lvlmode_o
);
    for (genvar i = 1; i <= N; i++) begin : g_det
        trig_mode_e md;
        logic       rise, fall;
        assign md   = trig_mode_e'(mode_i[2*i+1:2*i]);
        assign rise = lvl_i[i] & ~prev_i[i];
        assign fall = ~lvl_i[i] & prev_i[i];
        always_comb begin
            unique case (md)
                TRIG_RISE: hit_o[i] = rise;
                TRIG_FALL: hit_o[i] = fall;
                TRIG_BOTH: hit_o[i] = rise | fall;
                default:   hit_o[i] = 1'b0;
            endcase
        end
        assign lvlmode_o[i] = (md == TRIG_LEVEL);
    end
endmodule

// File: rtl/irq_ep_req.sv
module irq_ep_req #(
    parameter int N = 7
) (
    input  logic [N:1] flag_i,
    input  logic [N:1] en_i,
    input  logic [N:1] lvlmode_i,
    input  logic [N:1] lvl_i,
    output logic [N:1] irq_o
);
    for (genvar i = 1; i <= N; i++) begin : g_req
        assign irq_o[i] = en_i[i] & (lvlmode_i[i] ? ~lvl_i[i] : flag_i[i]);
    end
endmodule

// File: rtl/irq_edge_port.sv
module irq_edge_port
    import irq_ep_pkg::*;
#(
    parameter int NPINS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS:1]    pin_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NPINS:1]    irq_o
);
    // byte layout supports 4..7 pins
    localparam int MODE_W = 2 * NPINS + 2;
    localparam int HI_W   = MODE_W - 8;

    typedef struct packed {
        logic [NPINS:1]    flag;
        logic [MODE_W-1:0] mode;
        logic [NPINS:1]    en;
    } ep_state_t;

    ep_state_t st_d, st_q;

    logic [NPINS:1] lvl, prev, hit, lvlmode, clr;

    irq_ep_sync #(.N(NPINS), .STAGES(2)) u_sync (
        .clk    (clk),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    irq_ep_edge #(.N(NPINS)) u_edge (
        .mode_i    (st_q.mode),
        .lvl_i     (lvl),
        .prev_i    (prev),
        .hit_o     (hit),
        .lvlmode_o (lvlmode)
    );

    irq_ep_req #(.N(NPINS)) u_req (
        .flag_i    (st_q.flag),
        .en_i      (st_q.en),
        .lvlmode_i (lvlmode),
        .lvl_i     (lvl),
        .irq_o     (irq_o)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (we_i) begin
            unique case (addr_i)
                REG_FLAGS:   clr = wdata_i[NPINS:1];
                REG_MODE_LO: st_d.mode[7:2] = wdata_i[7:2];
                REG_MODE_HI: st_d.mode[MODE_W-1:8] = wdata_i[HI_W-1:0];
                REG_ENABLE:  st_d.en = wdata_i[NPINS:1];
                default:     ;
            endcase
        end
        // a fresh edge overrides a simultaneous clear
        st_d.flag = (st_q.flag & ~clr) | hit;
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            REG_LEVEL:   rdata_o[NPINS:1] = lvl;
            REG_FLAGS:   rdata_o[NPINS:1] = st_q.flag;
            REG_MODE_LO: rdata_o[7:2] = st_q.mode[7:2];
            REG_MODE_HI: rdata_o[HI_W-1:0] = st_q.mode[MODE_W-1:8];
            REG_ENABLE:  rdata_o[NPINS:1] = st_q.en;
            default:     rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_ep_chk.sv
module irq_ep_chk #(
    parameter int N = 7,
    localparam int MODE_W = 2 * N + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we_i,
    input logic [2:0]        addr_i,
    input logic [7:0]        wdata_i,
    input logic [N:1]        flag_q,
    input logic [MODE_W-1:0] mode_q,
    input logic [N:1]        en_q,
    input logic [N:1]        hit,
    input logic [N:1]        irq_o
);
    logic [N:1] lvl_mask, clr_vec;

    always_comb begin
        for (int i = 1; i <= N; i++) begin
            lvl_mask[i] = (mode_q[2*i +: 2] == 2'b00);
        end
        clr_vec = (we_i && addr_i == 3'd1) ? wdata_i[N:1] : '0;
    end

    // R5
    level_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & $past(lvl_mask)) == '0));

    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flag_q) & ~$past(clr_vec) & ~flag_q) == '0));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'd1) |=> ((flag_q & $past(wdata_i[N:1]) & ~$past(hit)) == '0));

    // R8
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(hit) & ~flag_q) == '0));

    // R10
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~en_q) == '0));
endmodule

bind irq_edge_port irq_ep_chk #(.N(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_q  (st_q.flag),
    .mode_q  (st_q.mode),
    .en_q    (st_q.en),
    .hit     (hit),
    .irq_o   (irq_o)
);

// File: tb/tb_irq_edge_port.sv
`timescale 1ns/100ps
module tb_irq_edge_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:1] pin_i = 7'h7F;
    logic       we_i = 1'b0;
    logic [2:0] addr_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic [7:1] irq_o;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_edge_port dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // behavioural model: sample history, flags, modes, enables
    logic [7:1] m1 = '0, m2 = '0, m3 = '0;
    logic [7:1] r_flag = '0, r_en = '0;
    logic [15:0] r_mode = '0;

    always @(posedge clk) begin
        logic [7:1] newhit;
        logic [7:1] clrv;
        for (int n = 1; n <= 7; n++) begin
            int md;
            md = int'(r_mode[2*n +: 2]);
            newhit[n] = ((md == 1 || md == 3) && m2[n] && !m3[n]) ||
                        ((md == 2 || md == 3) && !m2[n] && m3[n]);
        end
        clrv = (we_i && addr_i == 3'd1) ? wdata_i[7:1] : 7'h0;
        if (!rst_n) begin
            r_flag = '0; r_mode = '0; r_en = '0;
        end else begin
            r_flag = (r_flag & ~clrv) | newhit;
            if (we_i && addr_i == 3'd2) r_mode[7:2] = wdata_i[7:2];
            if (we_i && addr_i == 3'd3) r_mode[15:8] = wdata_i;
            if (we_i && addr_i == 3'd4) r_en = wdata_i[7:1];
        end
        m3 = m2; m2 = m1; m1 = pin_i;
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {m2, 1'b0};
            3'd1: return {r_flag, 1'b0};
            3'd2: return {r_mode[7:2], 2'b00};
            3'd3: return r_mode[15:8];
            3'd4: return {r_en, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:1] exp_irq();
        logic [7:1] v;
        for (int n = 1; n <= 7; n++) begin
            v[n] = r_en[n] && ((r_mode[2*n +: 2] == 2'b00) ? !m2[n] : r_flag[n]);
        end
        return v;
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R1";
            3'd1: return "R4";
            3'd2, 3'd3: return "R3";
            3'd4: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (chk_en && !done) begin
            chk(tag_of(addr_i), rdata_o, exp_rd(addr_i));
            chk("R10", {irq_o, 1'b0}, {exp_irq(), 1'b0});
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        we_i = 1'b0; wdata_i = 8'h00;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr_i = a;
        #1;
        chk(tag, rdata_o, exp);
    endtask

    task automatic irq_chk(input logic [7:0] exp, input string tag);
        @(negedge clk);
        #1;
        chk(tag, {irq_o, 1'b0}, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(4);
        chk_en = 1'b1;

        // R9 reset state, R1 levels, R11 reserved bit
        rd_chk(3'd1, 8'h00, "R9");
        rd_chk(3'd2, 8'h00, "R9");
        rd_chk(3'd4, 8'h00, "R9");
        rd_chk(3'd0, 8'hFE, "R1");
        rd_chk(3'd5, 8'h00, "R11");

        // R2 write to level register ignored
        wr(3'd0, 8'h00);
        rd_chk(3'd0, 8'hFE, "R2");

        // R3 modes: pin1 rise, pin2 fall, pin3 both; bits 1:0 stay 0
        wr(3'd2, 8'hE7);
        rd_chk(3'd2, 8'hE4, "R3");

        // R4 falling edges on pins 2 and 3
        @(negedge clk); pin_i[2] = 1'b0; pin_i[3] = 1'b0;
        cyc(4);
        rd_chk(3'd1, 8'h0C, "R4");
        // R4 falling on a rising-mode pin: no flag
        @(negedge clk); pin_i[1] = 1'b0;
        cyc(4);
        rd_chk(3'd1, 8'h0C, "R4");
        @(negedge clk); pin_i[1] = 1'b1;
        cyc(4);
        rd_chk(3'd1, 8'h0E, "R4");

        // R5 level-mode pin toggling
        @(negedge clk); pin_i[5] = 1'b0;
        cyc(3);
        @(negedge clk); pin_i[5] = 1'b1;
        cyc(4);
        rd_chk(3'd1, 8'h0E, "R5");

        // R6 write zero, R7 write one, R11 reserved bit
        wr(3'd1, 8'h00);
        rd_chk(3'd1, 8'h0E, "R6");
        wr(3'd1, 8'h04);
        rd_chk(3'd1, 8'h0A, "R7");
        wr(3'd1, 8'h01);
        rd_chk(3'd1, 8'h0A, "R11");

        // R8 edge on pin3 coincides with a clear of pin3
        @(negedge clk); pin_i[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); we_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h08;
        @(negedge clk); we_i = 1'b0; wdata_i = 8'h00;
        rd_chk(3'd1, 8'h0A, "R8");
        wr(3'd1, 8'h08);
        rd_chk(3'd1, 8'h02, "R7");

        // R10 request generation
        irq_chk(8'h00, "R10");
        wr(3'd4, 8'hFE);
        irq_chk(8'h02, "R10");
        @(negedge clk); pin_i[5] = 1'b0;
        cyc(3);
        irq_chk(8'h22, "R10");
        wr(3'd4, 8'h20);
        irq_chk(8'h20, "R10");
        wr(3'd4, 8'h00);
        irq_chk(8'h00, "R10");

        // R2 level register through reset, R9 state cleared
        wr(3'd4, 8'hFE);
        wr(3'd3, 8'h55);
        @(negedge clk); rst_n = 1'b0;
        cyc(2);
        rd_chk(3'd0, 8'hDA, "R2");
        @(negedge clk); rst_n = 1'b1;
        rd_chk(3'd1, 8'h00, "R9");
        rd_chk(3'd3, 8'h00, "R9");
        rd_chk(3'd4, 8'h00, "R9");
        irq_chk(8'h00, "R9");
        rd_chk(3'd0, 8'hDA, "R1");

        cyc(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule